// File: doc/BRIEF.md
# Power-Up Connectivity Test Tree

This block gives a board tester a way to check the solder joints of a set of digital pins without running any functional traffic. The mode is armed only in the window between power-up reset and the first write to the configuration register. In that window, a high level on a dedicated test-request pin arms it. The first configuration write closes the window, and no later activity can reopen it until the next power-up reset.

While the mode is active, a chain of two-input NAND stages combines the included pins into one bit. That bit is driven out on the pad that otherwise carries address bit 0. The tester first drives every included pin high and reads a 1. It then pulls the pins low one at a time, starting at index 0 and moving upward while keeping the earlier pins low. The pad changes level at every step. Outside test mode, the address pad's output driver is off and the pad behaves as an ordinary input.

The chain is purely combinational, so it tracks the pins directly. The entry and lockout logic is clocked and runs off an internally synchronised reset.

Top module: `ntree_top`

## Requirements
- R1: While reset is asserted, and for the synchronizer stages after it is released, `test_active_o` is 0 and `a0_pad_oe_o` is 0.
- R2: After reset, and before any configuration write, `test_req_i` high at a clock edge with `cfg_wr_i` low sets `test_active_o` to 1 from the next cycle. It stays 1 after `test_req_i` returns low.
- R3: A clock edge with `cfg_wr_i` high clears `test_active_o` from the next cycle.
- R4: Once any configuration write has occurred, `test_req_i` high has no effect on `test_active_o` until the next reset.
- R5: If `cfg_wr_i` and `test_req_i` are both high at the first edge after reset, the write wins and the mode stays off for good.
- R6: In test mode with every bit of `tree_pins_i` at 1, `a0_pad_o` is 1.
- R7: In test mode, with pins 0 to m-1 low and the rest high, `a0_pad_o` equals 1 when m is even and 0 when m is odd. Each additional pin pulled low in index order therefore toggles the pad.
- R8: In test mode, for any pin pattern, `a0_pad_o` is 1 if no pin is low. Otherwise it equals bit 0 of the index of the highest-numbered low pin.
- R9: Outside test mode, `a0_pad_oe_o` is 0, `a0_pad_o` is 0, and `a0_core_o` follows `a0_pad_i`.
- R10: In test mode, `a0_pad_oe_o` is 1 and `a0_core_o` is held at 0.
- R11: A new reset reopens the entry window, so test mode can be entered again after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous assert |
| test_req_i | input | 1 | Test-request pin level |
| cfg_wr_i | input | 1 | Configuration register write strobe |
| tree_pins_i | input | N_PINS | Included pins, index 0 first in test order |
| a0_pad_i | input | 1 | Address bit 0 pad input level |
| a0_pad_o | output | 1 | Value driven onto the address bit 0 pad |
| a0_pad_oe_o | output | 1 | Output enable for the address bit 0 pad |
| a0_core_o | output | 1 | Address bit 0 as seen by the core |
| test_active_o | output | 1 | Test mode active |

## Verification
The bench builds two copies of the block, one with N_PINS = 6 and one with N_PINS = 5. This covers both chain lengths, where the final polarity stage is either present or absent. Widths this small let every one of the 64 and 32 pin patterns be compared against the arithmetic rule on the highest-numbered low pin. The same build also runs the ordered pull-down walk and the entry and lockout sequences, including a write that coincides with the request and a second reset.

// File: rtl/ntree_pkg.sv
package ntree_pkg;

  typedef enum logic [1:0] {
    ENTRY_OPEN = 2'b00,
    ENTRY_TEST = 2'b01,
    ENTRY_SHUT = 2'b10
  } entry_state_t;

  function automatic bit needs_flip(input int n_pins);
    return (n_pins % 2) == 1;
  endfunction

endpackage

// File: rtl/ntree_rst_sync.sv
module ntree_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] shift_q;
  logic [LAST:0] shift_d;

  generate
    if (STAGES == 1) begin : g_one
      assign shift_d = 1'b1;
    end else begin : g_many
      assign shift_d = {shift_q[LAST-1:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) shift_q <= '0;
    else              shift_q <= shift_d;
  end

  assign rst_n_sync = shift_q[LAST];

endmodule

// File: rtl/ntree_entry.sv
module ntree_entry
  import ntree_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic test_req_i,
  input  logic cfg_wr_i,
  output logic test_active_o
);

  entry_state_t state_q;
  entry_state_t state_d;
  logic         state_en;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ENTRY_OPEN: begin
        if (cfg_wr_i)        state_d = ENTRY_SHUT;
        else if (test_req_i) state_d = ENTRY_TEST;
      end
      ENTRY_TEST: begin
        if (cfg_wr_i) state_d = ENTRY_SHUT;
      end
      ENTRY_SHUT: state_d = ENTRY_SHUT;
      default:    state_d = ENTRY_SHUT;
    endcase
  end

  assign state_en = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= ENTRY_OPEN;
    else if (state_en) state_q <= state_d;
  end

  assign test_active_o = (state_q == ENTRY_TEST);

endmodule

// File: rtl/ntree_chain.sv
module ntree_chain
  import ntree_pkg::*;
#(
  parameter int N_PINS = 8
) (
  input  logic [N_PINS-1:0] pins_i,
  output logic              tree_o
);

  localparam bit FLIP = needs_flip(N_PINS);
  localparam int LAST = N_PINS - 1;

  logic [LAST:0] stage;

  assign stage[0] = ~pins_i[0];

  generate
    for (genvar g = 1; g < N_PINS; g++) begin : g_stage
      assign stage[g] = ~(stage[g-1] & pins_i[g]);
    end
    if (FLIP) begin : g_flip
      assign tree_o = ~stage[LAST];
    end else begin : g_pass
      assign tree_o = stage[LAST];
    end
  endgenerate

endmodule

// File: rtl/ntree_padmux.sv
module ntree_padmux (
  input  logic test_active_i,
  input  logic tree_i,
  input  logic pad_i,
  output logic pad_o,
  output logic pad_oe_o,
  output logic core_o
);

  always_comb begin
    pad_oe_o = test_active_i;
    pad_o    = test_active_i & tree_i;
    core_o   = test_active_i ? 1'b0 : pad_i;
  end

endmodule

// File: rtl/ntree_top.sv
module ntree_top #(
  parameter int N_PINS     = 8,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_req_i,
  input  logic              cfg_wr_i,
  input  logic [N_PINS-1:0] tree_pins_i,
  input  logic              a0_pad_i,
  output logic              a0_pad_o,
  output logic              a0_pad_oe_o,
  output logic              a0_core_o,
  output logic              test_active_o
);

  logic rst_sync_n;
  logic tree_bit;
  logic active;

  ntree_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n_async(rst_n),
    .rst_n_sync (rst_sync_n)
  );

  ntree_entry u_entry (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .test_req_i   (test_req_i),
    .cfg_wr_i     (cfg_wr_i),
    .test_active_o(active)
  );

  ntree_chain #(.N_PINS(N_PINS)) u_chain (
    .pins_i(tree_pins_i),
    .tree_o(tree_bit)
  );

  ntree_padmux u_mux (
    .test_active_i(active),
    .tree_i       (tree_bit),
    .pad_i        (a0_pad_i),
    .pad_o        (a0_pad_o),
    .pad_oe_o     (a0_pad_oe_o),
    .core_o       (a0_core_o)
  );

  assign test_active_o = active;

endmodule

// File: rtl/ntree_checker.sv
module ntree_checker #(
  parameter int N_PINS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              test_req_i,
  input logic              cfg_wr_i,
  input logic [N_PINS-1:0] tree_pins_i,
  input logic              a0_pad_i,
  input logic              a0_pad_o,
  input logic              a0_pad_oe_o,
  input logic              a0_core_o,
  input logic              test_active_o
);

  logic seen_wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        seen_wr_q <= 1'b0;
    else if (cfg_wr_i) seen_wr_q <= 1'b1;
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (!test_active_o && !a0_pad_oe_o));

  assert_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen_wr_q && test_req_i && !cfg_wr_i) |=> test_active_o);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (test_active_o && !cfg_wr_i) |=> test_active_o);

  // Covers R3 and R5: a write always wins.
  assert_write_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_i |=> !test_active_o);

  assert_lockout_R4: assert property (@(posedge clk) disable iff (!rst_n)
    seen_wr_q |-> !test_active_o);

  assert_all_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (test_active_o && (&tree_pins_i)) |-> a0_pad_o);

  assert_idle_pad_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !test_active_o |-> (!a0_pad_oe_o && !a0_pad_o && (a0_core_o == a0_pad_i)));

  assert_test_pad_R10: assert property (@(posedge clk) disable iff (!rst_n)
    test_active_o |-> (a0_pad_oe_o && !a0_core_o));

endmodule

bind ntree_top ntree_checker #(.N_PINS(N_PINS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .test_req_i   (test_req_i),
  .cfg_wr_i     (cfg_wr_i),
  .tree_pins_i  (tree_pins_i),
  .a0_pad_i     (a0_pad_i),
  .a0_pad_o     (a0_pad_o),
  .a0_pad_oe_o  (a0_pad_oe_o),
  .a0_core_o    (a0_core_o),
  .test_active_o(test_active_o)
);

// File: tb/ntree_top_test.sv
module ntree_top_test;

  logic       clk;
  logic       rst_n;
  logic       test_req;
  logic       cfg_wr;
  logic       pad_in;
  logic [5:0] pins6;
  logic [4:0] pins5;
  logic       pad6_o, oe6, core6, act6;
  logic       pad5_o, oe5, core5, act5;

  int checks   = 0;
  int failures = 0;

  ntree_top #(.N_PINS(6)) uut (
    .clk(clk), .rst_n(rst_n), .test_req_i(test_req), .cfg_wr_i(cfg_wr),
    .tree_pins_i(pins6), .a0_pad_i(pad_in), .a0_pad_o(pad6_o),
    .a0_pad_oe_o(oe6), .a0_core_o(core6), .test_active_o(act6)
  );

  ntree_top #(.N_PINS(5)) uut_odd (
    .clk(clk), .rst_n(rst_n), .test_req_i(test_req), .cfg_wr_i(cfg_wr),
    .tree_pins_i(pins5), .a0_pad_i(pad_in), .a0_pad_o(pad5_o),
    .a0_pad_oe_o(oe5), .a0_core_o(core5), .test_active_o(act5)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic model_out(input int v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      if (((v >> i) & 1) == 0) return i[0];
    end
    return 1'b1;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_mode(input string req, input logic exp_act);
    check({req, " active6"}, act6, exp_act);
    check({req, " active5"}, act5, exp_act);
    check({req, " oe6"}, oe6, exp_act);
    check({req, " oe5"}, oe5, exp_act);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; test_req = 1'b0; cfg_wr = 1'b0; pad_in = 1'b0;
    pins6 = '1; pins5 = '1;
    tick(3);
    check_mode("R1 reset", 1'b0);

    // R9: idle pad is a plain input
    for (int b = 0; b < 2; b++) begin
      pad_in = b[0];
      #1;
      check("R9 core6 follows pad", core6, b[0]);
      check("R9 core5 follows pad", core5, b[0]);
      check("R9 pad6 undriven", pad6_o, 1'b0);
    end

    rst_n = 1'b1;
    tick(5);
    check_mode("R2 no request stays off", 1'b0);

    test_req = 1'b1;
    tick(1);
    check_mode("R2 entry", 1'b1);
    test_req = 1'b0;
    tick(3);
    check_mode("R2 sticky", 1'b1);

    pad_in = 1'b1;
    #1;
    check("R10 core6 held low", core6, 1'b0);
    check("R10 core5 held low", core5, 1'b0);

    pins6 = '1; pins5 = '1;
    #1;
    check("R6 all ones n6", pad6_o, 1'b1);
    check("R6 all ones n5", pad5_o, 1'b1);

    // R7: ordered cumulative pull-down walk
    for (int m = 1; m <= 6; m++) begin
      pins6 = 6'h3f << m;
      #1;
      check($sformatf("R7 walk n6 m=%0d", m), pad6_o, ~m[0]);
    end
    for (int m = 1; m <= 5; m++) begin
      pins5 = 5'h1f << m;
      #1;
      check($sformatf("R7 walk n5 m=%0d", m), pad5_o, ~m[0]);
    end

    // R8: exhaustive pattern sweep
    for (int v = 0; v < 64; v++) begin
      pins6 = v[5:0];
      pins5 = v[4:0];
      #1;
      check($sformatf("R8 n6 v=%0d", v), pad6_o, model_out(v, 6));
      if (v < 32) check($sformatf("R8 n5 v=%0d", v), pad5_o, model_out(v, 5));
    end

    cfg_wr = 1'b1;
    tick(1);
    cfg_wr = 1'b0;
    check_mode("R3 write clears", 1'b0);
    pad_in = 1'b1;
    #1;
    check("R9 core6 after exit", core6, 1'b1);

    test_req = 1'b1;
    pins6 = '1;
    tick(5);
    check_mode("R4 locked out", 1'b0);
    check("R4 pad6 stays undriven", pad6_o, 1'b0);
    cfg_wr = 1'b1;
    tick(1);
    cfg_wr = 1'b0;
    tick(2);
    check_mode("R4 second write", 1'b0);

    // R5: write and request together at first edge after reset
    rst_n = 1'b0;
    cfg_wr = 1'b1;
    tick(2);
    rst_n = 1'b1;
    tick(5);
    cfg_wr = 1'b0;
    tick(3);
    check_mode("R5 write wins", 1'b0);

    // R11: new reset reopens the window
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(5);
    check_mode("R11 re-entry", 1'b1);
    test_req = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule